// File: doc/BRIEF.md
# Interrupt Event and Mask Register Bank with Set/Clear Access

This block holds a 32-bit interrupt event register and a 32-bit interrupt mask register, plus two smaller per-context event/mask pairs of eight bits each: one for transmit contexts and one for receive contexts. Software never writes a register's value directly. Every register has two write addresses. At the set address, each 1 in the written word sets the matching bit. At the clear address, each 1 clears the matching bit. A 0 bit at either address leaves the register bit unchanged.

Hardware raises an event bit when the matching event input goes from 0 to 1. A bit that is set stays set until software clears it. Bit 31 of the main mask is a master enable that gates the single interrupt line. Two bits of the main event register summarise the per-context registers. Bit 6 is the OR of the masked transmit context events. Bit 7 is the OR of the masked receive context events. Reading an event register at its clear address returns the events ANDed with the mask, which gives an interrupt handler the pending causes in one read.

The block has no sequencing of its own. Its only states are the register contents, and it has no state machine, states or transitions. The read port is combinational from the register contents. Writes and event edges take effect at the next rising clock edge.

Top module: `irq_setclr_bank`

## Requirements
- R1: After reset, all six registers read 0 at every address and `irq` is 0.
- R2: A write at a set address sets every register bit whose `wr_data` bit is 1 and leaves the other bits unchanged. The new value is readable after the next rising clock edge.
- R3: A write at a clear address clears every register bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R4: A 0-to-1 transition on `evt_in[i]` (for i other than 6 and 7) sets main event bit i. A transition on `tx_ctx_evt[k]` sets transmit context event bit k, and a transition on `rx_ctx_evt[k]` sets receive context event bit k. An input that stays high does not set the bit again after it has been cleared.
- R5: When an input transition and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R6: Word addresses are: 0 event set, 1 event clear, 2 mask set, 3 mask clear, 4 transmit-context event set, 5 transmit-context event clear, 6 transmit-context mask set, 7 transmit-context mask clear, 8 receive-context event set, 9 receive-context event clear, 10 receive-context mask set, 11 receive-context mask clear. Writes to addresses 12 to 15 change nothing, and reads of those addresses return 0.
- R7: Reading an event set address returns the raw event value. Reading an event clear address returns that value ANDed with the matching mask. Reading either mask address returns the mask.
- R8: `irq` is 1 exactly when mask bit 31 is 1 and, for some bit j from 0 to 30, both the event bit j and the mask bit j are 1.
- R9: Main event bit 6 reads as the OR of (transmit context events AND transmit context mask). Bit 7 reads as the same OR for the receive contexts. Writes to bits 6 and 7 of the main event register, and `evt_in[6]` and `evt_in[7]`, have no effect on these two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data (ones select bits) |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, combinational |
| evt_in | input | 32 | Main hardware event inputs |
| tx_ctx_evt | input | 8 | Transmit context event inputs |
| rx_ctx_evt | input | 8 | Receive context event inputs |
| irq | output | 1 | Interrupt request |

## Verification
Random writes spread over all sixteen addresses with random data check that set and clear differ from a direct write. In that stream, 0 bits must preserve earlier contents, and writes to unmapped addresses must leave every register untouched. Event inputs are toggled sparsely and sometimes held high. This checks that only rising edges set a bit and that a level held high does not set it again after a clear. Directed cases drive an input edge in the same cycle as a clear of that bit, write bits 6 and 7 directly, and toggle the master enable. These cases tell sticky capture apart from clear-wins priority, and stored summary bits apart from computed ones. After every cycle, all twelve addresses are read and compared, so a masked read can be told apart from a raw one.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int DATA_W     = 32;
    localparam int CTX_N      = 8;
    localparam int ADDR_W     = 4;
    localparam int TX_SUM_BIT = 6;
    localparam int RX_SUM_BIT = 7;
    localparam int MASTER_BIT = 31;

    typedef enum logic [ADDR_W-1:0] {
        A_EVT_SET  = 4'd0,
        A_EVT_CLR  = 4'd1,
        A_MSK_SET  = 4'd2,
        A_MSK_CLR  = 4'd3,
        A_TXE_SET  = 4'd4,
        A_TXE_CLR  = 4'd5,
        A_TXM_SET  = 4'd6,
        A_TXM_CLR  = 4'd7,
        A_RXE_SET  = 4'd8,
        A_RXE_CLR  = 4'd9,
        A_RXM_SET  = 4'd10,
        A_RXM_CLR  = 4'd11
    } reg_addr_e;

    localparam int REG_N = 6;

endpackage

// File: rtl/setclr_reg.sv
module setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_in,
    output logic [W-1:0] q
);

    logic [W-1:0] hw_prev;
    logic [W-1:0] edge_w;
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;
    logic [W-1:0] q_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hw_prev <= '0;
        else        hw_prev <= hw_in;
    end

    assign edge_w   = hw_in & ~hw_prev;
    assign set_bits = set_wr ? wdata : '0;
    assign clr_bits = clr_wr ? wdata : '0;

    // Clear is applied first; set and input edges then win over it.
    always_comb begin
        q_next = (q & ~clr_bits) | set_bits | edge_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((q & $past(wdata)) == $past(wdata)));

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_wr) |=> ((q & $past(wdata & ~edge_w)) == '0));

    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((q & $past(q)) == $past(q)));

    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w != '0) |=> ((q & $past(edge_w)) == $past(edge_w)));

endmodule

// File: rtl/irq_setclr_bank.sv
module irq_setclr_bank
    import irq_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [DATA_W-1:0]    evt_in,
    input  logic [CTX_N-1:0]     tx_ctx_evt,
    input  logic [CTX_N-1:0]     rx_ctx_evt,
    output logic                 irq
);

    localparam logic [DATA_W-1:0] SUM_MASK =
        (DATA_W'(1) << TX_SUM_BIT) | (DATA_W'(1) << RX_SUM_BIT);

    // Strobe vectors, one bit per register: 0 evt, 1 msk, 2 txe, 3 txm, 4 rxe, 5 rxm
    logic [REG_N-1:0] set_stb;
    logic [REG_N-1:0] clr_stb;

    always_comb begin
        set_stb = '0;
        clr_stb = '0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_EVT_SET: set_stb[0] = 1'b1;
                A_EVT_CLR: clr_stb[0] = 1'b1;
                A_MSK_SET: set_stb[1] = 1'b1;
                A_MSK_CLR: clr_stb[1] = 1'b1;
                A_TXE_SET: set_stb[2] = 1'b1;
                A_TXE_CLR: clr_stb[2] = 1'b1;
                A_TXM_SET: set_stb[3] = 1'b1;
                A_TXM_CLR: clr_stb[3] = 1'b1;
                A_RXE_SET: set_stb[4] = 1'b1;
                A_RXE_CLR: clr_stb[4] = 1'b1;
                A_RXM_SET: set_stb[5] = 1'b1;
                A_RXM_CLR: clr_stb[5] = 1'b1;
                default: ;
            endcase
        end
    end

    logic [DATA_W-1:0] evt_q, msk_q, evt_eff;
    logic [CTX_N-1:0]  txe_q, txm_q, rxe_q, rxm_q;
    logic              tx_sum, rx_sum;

    // Summary bits are computed, so they are never stored in the main register.
    setclr_reg #(.W(DATA_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_wr(set_stb[0]), .clr_wr(clr_stb[0]),
        .wdata(wr_data & ~SUM_MASK), .hw_in(evt_in & ~SUM_MASK), .q(evt_q));

    setclr_reg #(.W(DATA_W)) u_msk (
        .clk(clk), .rst_n(rst_n), .set_wr(set_stb[1]), .clr_wr(clr_stb[1]),
        .wdata(wr_data), .hw_in('0), .q(msk_q));

    setclr_reg #(.W(CTX_N)) u_txe (
        .clk(clk), .rst_n(rst_n), .set_wr(set_stb[2]), .clr_wr(clr_stb[2]),
        .wdata(wr_data[CTX_N-1:0]), .hw_in(tx_ctx_evt), .q(txe_q));

    setclr_reg #(.W(CTX_N)) u_txm (
        .clk(clk), .rst_n(rst_n), .set_wr(set_stb[3]), .clr_wr(clr_stb[3]),
        .wdata(wr_data[CTX_N-1:0]), .hw_in('0), .q(txm_q));

    setclr_reg #(.W(CTX_N)) u_rxe (
        .clk(clk), .rst_n(rst_n), .set_wr(set_stb[4]), .clr_wr(clr_stb[4]),
        .wdata(wr_data[CTX_N-1:0]), .hw_in(rx_ctx_evt), .q(rxe_q));

    setclr_reg #(.W(CTX_N)) u_rxm (
        .clk(clk), .rst_n(rst_n), .set_wr(set_stb[5]), .clr_wr(clr_stb[5]),
        .wdata(wr_data[CTX_N-1:0]), .hw_in('0), .q(rxm_q));

    assign tx_sum = |(txe_q & txm_q);
    assign rx_sum = |(rxe_q & rxm_q);

    always_comb begin
        evt_eff             = evt_q;
        evt_eff[TX_SUM_BIT] = tx_sum;
        evt_eff[RX_SUM_BIT] = rx_sum;
    end

    assign irq = msk_q[MASTER_BIT] &
                 (|(evt_eff[MASTER_BIT-1:0] & msk_q[MASTER_BIT-1:0]));

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_EVT_SET: rd_data = evt_eff;
            A_EVT_CLR: rd_data = evt_eff & msk_q;
            A_MSK_SET,
            A_MSK_CLR: rd_data = msk_q;
            A_TXE_SET: rd_data = DATA_W'(txe_q);
            A_TXE_CLR: rd_data = DATA_W'(txe_q & txm_q);
            A_TXM_SET,
            A_TXM_CLR: rd_data = DATA_W'(txm_q);
            A_RXE_SET: rd_data = DATA_W'(rxe_q);
            A_RXE_CLR: rd_data = DATA_W'(rxe_q & rxm_q);
            A_RXM_SET,
            A_RXM_CLR: rd_data = DATA_W'(rxm_q);
            default:   rd_data = '0;
        endcase
    end

    a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !msk_q[MASTER_BIT] |-> !irq);

    a_r9_sum_tracks_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        ((txe_q & txm_q) == '0) |-> !evt_eff[TX_SUM_BIT]);

endmodule

// File: tb/irq_setclr_bank_tb.sv
`timescale 1ns/100ps
module irq_setclr_bank_tb;
    import irq_regs_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [3:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [31:0]       evt_in = '0;
    logic [7:0]        tx_ctx_evt = '0;
    logic [7:0]        rx_ctx_evt = '0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_setclr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_in(evt_in), .tx_ctx_evt(tx_ctx_evt), .rx_ctx_evt(rx_ctx_evt),
        .irq(irq));

    // Bench model of the register state
    logic [31:0] m_evt, m_msk, p_evt;
    logic [7:0]  m_txe, m_txm, m_rxe, m_rxm, p_tx, p_rx;

    function automatic logic [31:0] upd(logic [31:0] q, bit s, bit c,
                                        logic [31:0] d, logic [31:0] e);
        return (q & ~(c ? d : 32'h0)) | (s ? d : 32'h0) | e;
    endfunction

    function automatic logic [31:0] eff_evt();
        logic [31:0] v = m_evt & ~32'hC0;
        v[6] = |(m_txe & m_txm);
        v[7] = |(m_rxe & m_rxm);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(int a);
        case (a)
            0: return eff_evt();
            1: return eff_evt() & m_msk;
            2, 3: return m_msk;
            4: return {24'h0, m_txe};
            5: return {24'h0, m_txe & m_txm};
            6, 7: return {24'h0, m_txm};
            8: return {24'h0, m_rxe};
            9: return {24'h0, m_rxe & m_rxm};
            10, 11: return {24'h0, m_rxm};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic [31:0] e = eff_evt();
        return m_msk[31] & (|(e[30:0] & m_msk[30:0]));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read all addresses and irq; called shortly after a rising edge.
    task automatic check_all(string req);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.1;
            chk(req, rd_data, exp_read(a));
        end
        chk({req, " R8 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    // One cycle: drive at falling edge, update model at rising edge.
    task automatic step(bit we, int a, logic [31:0] d,
                        logic [31:0] ev, logic [7:0] tx, logic [7:0] rx);
        @(negedge clk);
        wr_en = we; wr_addr = 4'(a); wr_data = d;
        evt_in = ev; tx_ctx_evt = tx; rx_ctx_evt = rx;
        @(posedge clk);
        m_evt = upd(m_evt, we && a == 0, we && a == 1, d & ~32'hC0,
                    (ev & ~p_evt) & ~32'hC0);
        m_msk = upd(m_msk, we && a == 2, we && a == 3, d, 32'h0);
        m_txe = 8'(upd({24'h0, m_txe}, we && a == 4, we && a == 5, {24'h0, d[7:0]}, {24'h0, tx & ~p_tx}));
        m_txm = 8'(upd({24'h0, m_txm}, we && a == 6, we && a == 7, {24'h0, d[7:0]}, 32'h0));
        m_rxe = 8'(upd({24'h0, m_rxe}, we && a == 8, we && a == 9, {24'h0, d[7:0]}, {24'h0, rx & ~p_rx}));
        m_rxm = 8'(upd({24'h0, m_rxm}, we && a == 10, we && a == 11, {24'h0, d[7:0]}, 32'h0));
        p_evt = ev; p_tx = tx; p_rx = rx;
        #0.3;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ev;
        logic [7:0] tx, rx;
        void'($urandom(32'h1394_5EED));
        m_evt = 0; m_msk = 0; m_txe = 0; m_txm = 0; m_rxe = 0; m_rxm = 0;
        p_evt = 0; p_tx = 0; p_rx = 0;
        repeat (3) @(posedge clk);
        #0.3;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #0.3;
        check_all("R1 after release");

        // R2/R7: set mask incl. master, set events, masked read
        step(1, 2, 32'h8000_00F1, 0, 0, 0); check_all("R2 mask set");
        step(1, 0, 32'h0000_0303, 0, 0, 0); check_all("R7 masked read R8");
        // R3: clear with zeros preserved
        step(1, 1, 32'h0000_0001, 0, 0, 0); check_all("R3 clear");
        // R4: edge sets, held level does not re-set after clear
        step(0, 0, 0, 32'h0000_0010, 0, 0); check_all("R4 edge");
        step(1, 1, 32'h0000_0010, 32'h0000_0010, 0, 0); check_all("R4 level held");
        step(0, 0, 0, 32'h0000_0010, 0, 0); check_all("R4 no reset by level");
        // R5: edge and clear same cycle
        step(0, 0, 0, 0, 0, 0);
        step(1, 1, 32'h0000_0020, 32'h0000_0020, 0, 0); check_all("R5 edge beats clear");
        // R9: direct writes and inputs on bits 6/7 ignored
        step(1, 0, 32'h0000_00C0, 32'h0000_00C0, 0, 0); check_all("R9 bits 6 7 ignored");
        // R9: context summary
        step(1, 6, 32'h0000_0004, 0, 8'h04, 0); check_all("R9 tx summary");
        step(1, 10, 32'h0000_0080, 0, 0, 8'h80); check_all("R9 rx summary");
        step(1, 5, 32'h0000_0004, 0, 0, 8'h80); check_all("R9 tx summary clears");
        // R8: master disable
        step(1, 3, 32'h8000_0000, 0, 0, 8'h80); check_all("R8 master off");
        // R6: unmapped writes
        step(1, 12, 32'hFFFF_FFFF, 0, 0, 0); check_all("R6 unmapped 12");
        step(1, 15, 32'hFFFF_FFFF, 0, 0, 0); check_all("R6 unmapped 15");

        ev = 0; tx = 0; rx = 0;
        for (int i = 0; i < 600; i++) begin
            int a;
            logic [31:0] d;
            a = int'($urandom_range(0, 15));
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = 32'(1) << $urandom_range(0, 31);
            ev = ev ^ ((($urandom_range(0, 2) == 0) ? 32'(1) : 32'(0)) << $urandom_range(0, 31));
            if ($urandom_range(0, 3) == 0) tx = tx ^ 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) rx = rx ^ 8'(1 << $urandom_range(0, 7));
            step($urandom_range(0, 3) != 0, a, d, ev, tx, rx);
            check_all("R2 R3 R4 R7 R9 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule